// File: doc/BRIEF.md
# Receive Frame Admission Controller with Watermark Hysteresis

This block decides, one frame at a time, whether a good received frame may go into the receive buffer or must be dropped. It watches the count of free buffers against two thresholds. While the free count is above the lower threshold, every frame is admitted. Once the free count falls to the lower threshold, the controller enters a low-buffer episode. In that episode it still admits a programmable number of good frames. When that allowance is used up, it drops every later frame until the free count climbs back to the upper threshold. That recovery ends the episode and resets the allowance.

The receive path raises a one-cycle frame-start strobe, along with a flag saying whether the frame is good. The controller registers its verdict on that edge, flags it valid for one cycle, and holds the verdict until the next frame start. The controller also reports whether it is in the dropping phase, and keeps a saturating count of the frames it has refused. The allowance is a 16-bit quantity whose reset value is zero. A value of zero means that frames are refused as soon as the low threshold is reached.

Top module: `rxadm_ctrl`

## Requirements
- R1: After reset, admit_o, dec_vld_o and drop_state_o are 0 and drop_cnt_o is 0.
- R2: dec_vld_o is 1 in exactly the cycle after a cycle with frm_start_i high. When no episode is active and free_cnt_i is above low_thr_i, that verdict is admit (admit_o = 1).
- R3: An episode starts in any cycle where free_cnt_i <= low_thr_i. In an episode, frames are admitted while the number of good frames already admitted in it is below max_frames_i. Each admitted good frame counts toward that number.
- R4: Once max_frames_i good frames have been admitted in the episode, every later frame is refused (admit_o = 0), and drop_state_o is 1.
- R5: When max_frames_i is 0, a frame is refused even if it starts in the same cycle that first sees free_cnt_i <= low_thr_i.
- R6: Frames with frm_good_i = 0 are admitted during the allowance but do not reduce it.
- R7: A cycle with free_cnt_i >= high_thr_i ends the episode and clears the allowance count. A frame starting in that cycle is admitted, and this takes priority even if the low condition also holds. drop_state_o is 0 in the next cycle.
- R8: admit_o changes only in the cycle after a frame start, and holds its value until the next one.
- R9: drop_cnt_o increases by one for each refused frame and stays at its all-ones maximum once it gets there.
- R10: The episode continues while free_cnt_i lies between the thresholds (above low_thr_i but below high_thr_i). A free count that rises above the low threshold alone does not restore admission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| free_cnt_i | input | FW | Current number of free receive buffers |
| low_thr_i | input | FW | Lower threshold, start of a low-buffer episode |
| high_thr_i | input | FW | Upper threshold, recovery point |
| frm_start_i | input | 1 | One-cycle strobe at the start of a received frame |
| frm_good_i | input | 1 | Frame is good, qualified by frm_start_i |
| max_frames_i | input | GW | Good frames admitted per episode after the low threshold |
| admit_o | output | 1 | Held verdict for the current frame: 1 = accept, 0 = drop |
| dec_vld_o | output | 1 | One-cycle pulse when a new verdict appears |
| drop_state_o | output | 1 | Episode active and allowance exhausted |
| drop_cnt_o | output | CNTW | Saturating count of refused frames |

## Verification
Two events can coincide: a frame start can land in the very cycle that the free count crosses a threshold. The bench places frame strobes in the cycle where the free count first reaches the low threshold, with a zero allowance and with a non-zero one. It also places them in the cycle where the free count returns to the upper threshold, including a setting where both conditions hold at once. A behavioural model settles each verdict on every clock: the low edge must count in that same cycle, and recovery must win over the low condition. A further collision happens when a refusal arrives while the drop counter is already full, which the bench reaches by using a narrow counter.

// File: rtl/rxadm_pkg.sv
package rxadm_pkg;
  // Watermark events seen in one cycle
  typedef struct packed {
    logic recover;  // free count at or above the upper threshold
    logic low_hit;  // free count at or below the lower threshold
  } wm_ev_t;
endpackage

// File: rtl/rxadm_wm_cmp.sv
module rxadm_wm_cmp
  import rxadm_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic [FW-1:0] free_cnt_i,
  input  logic [FW-1:0] low_thr_i,
  input  logic [FW-1:0] high_thr_i,
  output wm_ev_t        ev_o
);
  function automatic logic below_or_at(input logic [FW-1:0] f, input logic [FW-1:0] t);
    return f <= t;
  endfunction

  function automatic logic above_or_at(input logic [FW-1:0] f, input logic [FW-1:0] t);
    return f >= t;
  endfunction

  always_comb begin
    ev_o.low_hit = below_or_at(free_cnt_i, low_thr_i);
    ev_o.recover = above_or_at(free_cnt_i, high_thr_i);
  end
endmodule

// File: rtl/rxadm_grace.sv
module rxadm_grace
  import rxadm_pkg::*;
#(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wm_ev_t        ev_i,
  input  logic          frm_start_i,
  input  logic          frm_good_i,
  input  logic [GW-1:0] max_frames_i,
  output logic          admit_now_o,
  output logic          exhausted_o
);
  logic          low_q;
  logic [GW-1:0] grace_q;
  logic          eff_low;
  logic          room;
  logic          take_grace;

  function automatic logic has_room(input logic [GW-1:0] used, input logic [GW-1:0] lim);
    return used < lim;
  endfunction

  // Recovery outranks the low condition in the same cycle
  assign eff_low     = !ev_i.recover && (low_q || ev_i.low_hit);
  assign room        = has_room(grace_q, max_frames_i);
  assign admit_now_o = !eff_low || room;
  assign take_grace  = frm_start_i && frm_good_i && eff_low && room;
  assign exhausted_o = low_q && !room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= 1'b0;
      grace_q <= '0;
    end else if (ev_i.recover) begin
      low_q   <= 1'b0;
      grace_q <= '0;
    end else begin
      if (ev_i.low_hit) low_q <= 1'b1;
      if (take_grace)   grace_q <= grace_q + 1'b1;
    end
  end

  // R6: the allowance moves only on a good frame (or is cleared on recovery)
  p_grace_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_start_i && frm_good_i) && !ev_i.recover |=> $stable(grace_q));

  // R5: zero allowance refuses a frame arriving on the low edge
  p_zero_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.low_hit && !ev_i.recover && max_frames_i == '0) |-> !admit_now_o);

  // R7: recovery clears the episode by the next cycle
  p_recover_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.recover |=> (!low_q && grace_q == '0));
endmodule

// File: rtl/rxadm_drop_ctr.sv
module rxadm_drop_ctr #(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  output logic [CNTW-1:0] cnt_o
);
  function automatic logic [CNTW-1:0] sat_inc(input logic [CNTW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (inc_i) cnt_o <= sat_inc(cnt_o);
  end

  // R9: a full counter never wraps
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_o) |=> (&cnt_o));

  // R9: one step per refusal
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !(&cnt_o)) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/rxadm_ctrl.sv
module rxadm_ctrl
  import rxadm_pkg::*;
#(
  parameter int FW   = 12,
  parameter int GW   = 16,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FW-1:0]   free_cnt_i,
  input  logic [FW-1:0]   low_thr_i,
  input  logic [FW-1:0]   high_thr_i,
  input  logic            frm_start_i,
  input  logic            frm_good_i,
  input  logic [GW-1:0]   max_frames_i,
  output logic            admit_o,
  output logic            dec_vld_o,
  output logic            drop_state_o,
  output logic [CNTW-1:0] drop_cnt_o
);
  wm_ev_t wm_ev;
  logic   admit_now;
  logic   refuse_evt;

  rxadm_wm_cmp #(.FW(FW)) u_cmp (
    .free_cnt_i (free_cnt_i),
    .low_thr_i  (low_thr_i),
    .high_thr_i (high_thr_i),
    .ev_o       (wm_ev)
  );

  rxadm_grace #(.GW(GW)) u_grace (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_i         (wm_ev),
    .frm_start_i  (frm_start_i),
    .frm_good_i   (frm_good_i),
    .max_frames_i (max_frames_i),
    .admit_now_o  (admit_now),
    .exhausted_o  (drop_state_o)
  );

  assign refuse_evt = frm_start_i && !admit_now;

  rxadm_drop_ctr #(.CNTW(CNTW)) u_dctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (refuse_evt),
    .cnt_o (drop_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      admit_o   <= 1'b0;
      dec_vld_o <= 1'b0;
    end else begin
      dec_vld_o <= frm_start_i;
      if (frm_start_i) admit_o <= admit_now;
    end
  end

  // R8: verdict held between frame starts
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start_i |=> $stable(admit_o));

  // R2: a valid pulse follows every frame start
  p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_i |=> dec_vld_o);

  // R7: a frame starting on recovery is admitted
  p_recover_admit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start_i && free_cnt_i >= high_thr_i) |=> admit_o);

  // R7: drop state released after recovery
  p_recover_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt_i >= high_thr_i) |=> !drop_state_o);
endmodule

// File: tb/rxadm_ctrl_bench.sv
`timescale 1ns/100ps
module rxadm_ctrl_bench;
  localparam int FW = 12;
  localparam int GW = 16;
  localparam int CNTW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0] free_cnt = 12'd100;
  logic [FW-1:0] low_thr = 12'd20;
  logic [FW-1:0] high_thr = 12'd60;
  logic frm_start = 1'b0;
  logic frm_good = 1'b0;
  logic [GW-1:0] max_frames = '0;
  logic admit;
  logic dec_vld;
  logic drop_state;
  logic [CNTW-1:0] drop_cnt;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 0;

  // reference model state
  bit m_low = 0;
  int m_grace = 0;
  bit m_admit = 0;
  bit m_vld = 0;
  int m_dcnt = 0;

  always #2.5 clk = ~clk;

  rxadm_ctrl #(.FW(FW), .GW(GW), .CNTW(CNTW)) u_rxadm_ctrl (
    .clk(clk), .rst_n(rst_n), .free_cnt_i(free_cnt), .low_thr_i(low_thr),
    .high_thr_i(high_thr), .frm_start_i(frm_start), .frm_good_i(frm_good),
    .max_frames_i(max_frames), .admit_o(admit), .dec_vld_o(dec_vld),
    .drop_state_o(drop_state), .drop_cnt_o(drop_cnt)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // advance one clock, step the model with the inputs held across that edge, compare
  task automatic tick();
    bit rec, hit, el, room, adm;
    @(posedge clk);
    #1;
    rec = (free_cnt >= high_thr);
    hit = (free_cnt <= low_thr);
    el = !rec && (m_low || hit);
    room = (m_grace < int'(max_frames));
    adm = !el || room;
    m_vld = frm_start;
    if (frm_start) begin
      m_admit = adm;
      if (!adm && m_dcnt < 15) m_dcnt++;
      if (frm_good && el && room) m_grace++;
    end
    if (rec) begin m_low = 0; m_grace = 0; end
    else if (hit) m_low = 1;
    chk({phase, " admit"}, admit, m_admit);
    chk({phase, " dec_vld"}, dec_vld, m_vld);
    chk({phase, " drop_state"}, drop_state, m_low && !(m_grace < int'(max_frames)));
    chk({phase, " drop_cnt"}, drop_cnt, m_dcnt);
  endtask

  // one frame: strobe for a cycle, then an idle cycle; returns the verdict
  task automatic frame(input bit good, output bit verdict);
    frm_start = 1'b1;
    frm_good = good;
    tick();
    verdict = admit;
    frm_start = 1'b0;
    frm_good = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    bit v;
    max_frames = 16'd3;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 admit", admit, 0);
    chk("R1 dec_vld", dec_vld, 0);
    chk("R1 drop_state", drop_state, 0);
    chk("R1 drop_cnt", drop_cnt, 0);
    rst_n = 1'b1;
    tick();

    phase = "R2";
    for (int i = 0; i < 3; i++) begin
      frame(1'b1, v);
      chk("R2 admit above low", v, 1);
    end

    phase = "R6";
    free_cnt = 12'd20;
    for (int i = 0; i < 4; i++) begin
      frame(1'b0, v);
      chk("R6 bad frame in allowance", v, 1);
    end

    phase = "R3";
    for (int i = 0; i < 3; i++) begin
      frame(1'b1, v);
      chk("R3 grace admit", v, 1);
    end
    phase = "R4";
    frame(1'b1, v);
    chk("R4 refused after allowance", v, 0);
    chk("R4 drop_state", drop_state, 1);
    frame(1'b0, v);
    chk("R4 bad frame refused", v, 0);

    phase = "R10";
    free_cnt = 12'd40;
    frame(1'b1, v);
    chk("R10 between thresholds", v, 0);
    free_cnt = 12'd59;
    frame(1'b1, v);
    chk("R10 just below high", v, 0);

    phase = "R7";
    free_cnt = 12'd60;
    frame(1'b1, v);
    chk("R7 frame on recovery", v, 1);
    chk("R7 drop_state cleared", drop_state, 0);
    // both conditions at once: recovery wins
    low_thr = 12'd80;
    free_cnt = 12'd70;
    frame(1'b1, v);
    chk("R7 recovery over low", v, 1);
    low_thr = 12'd20;
    tick();

    phase = "R5";
    max_frames = '0;
    free_cnt = 12'd10;
    frame(1'b1, v);
    chk("R5 refused on low edge", v, 0);
    free_cnt = 12'd100;
    tick();

    phase = "R3";
    max_frames = 16'd1;
    free_cnt = 12'd20;
    frame(1'b1, v);
    chk("R3 low edge counts, allowance 1", v, 1);
    frame(1'b1, v);
    chk("R3 second frame refused", v, 0);

    phase = "R8";
    repeat (5) tick();
    chk("R8 verdict held", admit, 0);

    phase = "R9";
    for (int i = 0; i < 16; i++) frame(i[0], v);
    chk("R9 saturated", drop_cnt, 15);
    frame(1'b1, v);
    chk("R9 stays full", drop_cnt, 15);

    phase = "R2";
    free_cnt = 12'd100;
    frame(1'b1, v);
    chk("R2 admit after recovery", v, 1);

    report();
  end
endmodule